// File: doc/BRIEF.md
# Multiplexed Host Register Bus Slave

This block lets a host reach a bank of 8-bit registers over a narrow bus. Eight bus lines carry either a register index or a data byte, and a phase-select line says which. An access always comes in two steps. First the host writes an index with the select line high. Then it reads or writes data with the select line low, aimed at the index latched in the first step. The index stays latched, so later data accesses can reuse it without a new index step.

All bus inputs pass through a two-stage synchronizer into the core clock. The block acts on the falling edge of a write or read strobe, and only while chip select is low. For each data access it produces a one-cycle write or read enable for the selected downstream register. It takes read data from a flat bank vector that downstream logic supplies. The ready output stays at its not-ready level for a fixed number of core cycles after each strobe edge. With the `USE_ACK` option set, it instead waits for a downstream acknowledge on externally handled registers.

Two indices are handled inside the block. Index 0x00 is the interrupt control register, which holds the source enables and the pending flags that drive the active-low interrupt pin. Index 0x0F returns a fixed revision byte.

Top module: `mhb_regif`

## Requirements
- R1: A write strobe with phase select high (1) loads the bus byte into the index latch. It pulses no register enable.
- R2: A write strobe with phase select low (0) to a mapped external index drives `reg_wr_en` high for exactly one core cycle. Bit position equals the latched index, and `reg_wdata` carries the bus byte. The mapped indices are 0x00, 0x01, 0x04–0x0A, 0x0C, 0x0D and 0x0F; all of them except 0x00 and 0x0F are external.
- R3: A read strobe with phase select low to a mapped external index pulses the matching `reg_rd_en` bit for one cycle. It returns byte `idx` of `reg_rdata_bank` (bits idx*8+7..idx*8) on `bus_dout`. `bus_doe` is high only while both `bus_cs_n` and `bus_rd_n` are low.
- R4: Strobes while `bus_cs_n` is high change nothing: the index is kept, no enable pulses, and ready stays low.
- R5: A read of an unmapped index (for example 0x02 or 0x40) returns 0x00. A write to an unmapped index pulses no enable.
- R6: Reading index 0x0F returns the `REVISION` parameter (default 0x21). Writes to 0x0F are ignored.
- R7: After every strobe edge that is acted on, `bus_rdy_n` is high for exactly `READY_CYC` core cycles (default 2) and then returns low.
- R8: Writing interrupt control (index 0x00) loads source enables. Bit 2 enables source 0 and bit 6 enables source 1, so 0x44 enables both. A high `irq_src[k]` with its enable set marks source k pending and drives `bus_irq_n` low.
- R9: Reading interrupt control returns enables in bits 2/6 and pending flags in bits 0/4 (source 0/1). The read clears the pending flags, so `bus_irq_n` returns high.
- R10: A source whose enable bit is 0 never becomes pending and never pulls `bus_irq_n` low.
- R11: After reset, `bus_rdy_n` is 0, `bus_irq_n` is 1, `bus_doe` is 0, no enables are active, and the index latch holds 0x00, so a first data read returns interrupt control = 0x00.
- R12: The latched index persists across several data accesses until the next index write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_ad_sel | input | 1 | Phase select: 1 = index, 0 = data |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_din | input | 8 | Bus byte from host |
| bus_dout | output | 8 | Bus byte to host |
| bus_doe | output | 1 | Output enable for the shared bus lines |
| bus_rdy_n | output | 1 | Ready, active low (high = busy) |
| bus_irq_n | output | 1 | Interrupt request, active low |
| reg_wr_en | output | NREG | One-cycle write enable per external register |
| reg_rd_en | output | NREG | One-cycle read enable per external register |
| reg_wdata | output | 8 | Write data for the enabled register |
| reg_rdata_bank | input | NREG*8 | Current contents of all external registers |
| reg_ack | input | 1 | Downstream acknowledge (used when USE_ACK=1) |
| irq_src | input | 2 | Interrupt source levels, core clock domain |

## Verification
A table of index-then-data pairs over several external indices checks enable position, write byte and read byte together. This separates a wrong index latch from a wrong bank slice. Reused-index accesses check that the latch survives data phases, and strobes with chip select high check that the edge detector is gated. Interrupt sequences with enables off, with one source and then the other, and with repeated reads check the set, report and clear behaviour of the pending bits. Unmapped, revision and reset-state reads check the read multiplexer's fallback paths.

// File: rtl/mhb_pkg.sv
package mhb_pkg;
   localparam int unsigned MHB_DW       = 8;
   localparam int unsigned MHB_IDX_INT  = 0;
   localparam int unsigned MHB_IDX_REV  = 15;
   localparam logic [15:0] MHB_MAP_MASK = 16'hB7F3;
   localparam int unsigned MHB_NSRC     = 2;
   localparam int unsigned MHB_EN_OFS   = 2;
   localparam int unsigned MHB_SRC_STEP = 4;
endpackage

// File: rtl/mhb_sync.sv
module mhb_sync #(
   parameter int unsigned W = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1, stage2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= RST_VAL;
         stage2 <= RST_VAL;
      end else begin
         stage1 <= d;
         stage2 <= stage1;
      end
   end

   assign q = stage2;
endmodule

// File: rtl/mhb_phase.sv
module mhb_phase #(
   parameter int unsigned DW        = 8,
   parameter int unsigned READY_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_s,
   input  logic          ad_s,
   input  logic          wr_s,
   input  logic          rd_s,
   input  logic [DW-1:0] dat_s,
   input  logic          need_ack,
   input  logic          ack,
   output logic          ev_idx,
   output logic          ev_wr,
   output logic          ev_rd,
   output logic [DW-1:0] index,
   output logic          busy
);
   localparam int unsigned CNT_W = $clog2(READY_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(READY_CYC - 1);

   logic             wr_q, rd_q;
   logic             wr_fall, rd_fall, any_ev;
   logic             wait_ack;
   logic [CNT_W-1:0] cnt;
   logic             done;

   assign wr_fall = wr_q & ~wr_s & ~cs_s;
   assign rd_fall = rd_q & ~rd_s & ~cs_s;
   assign ev_idx  = wr_fall & ad_s;
   assign ev_wr   = wr_fall & ~ad_s;
   assign ev_rd   = rd_fall & ~wr_fall;
   assign any_ev  = ev_idx | ev_wr | ev_rd;
   assign done    = wait_ack ? ack : (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= 1'b1;
         rd_q  <= 1'b1;
         index <= '0;
      end else begin
         wr_q <= wr_s;
         rd_q <= rd_s;
         if (ev_idx) index <= dat_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         wait_ack <= 1'b0;
         cnt      <= '0;
      end else if (any_ev) begin
         busy     <= 1'b1;
         wait_ack <= need_ack & ~ev_idx;
         cnt      <= '0;
      end else if (busy) begin
         if (done) busy <= 1'b0;
         if (cnt != LAST) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mhb_decode.sv
module mhb_decode #(
   parameter int unsigned  NREG     = 16,
   parameter int unsigned  DW       = 8,
   parameter logic [NREG-1:0] MAP_MASK = '1,
   parameter int unsigned  IDX_INT  = 0,
   parameter int unsigned  IDX_REV  = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DW-1:0]   index,
   input  logic            ev_wr,
   input  logic            ev_rd,
   output logic            hit_int,
   output logic            hit_rev,
   output logic            hit_ext,
   output logic [NREG-1:0] wr_en,
   output logic [NREG-1:0] rd_en
);
   localparam logic [NREG-1:0] INT_BITS = (NREG'(1) << IDX_INT) | (NREG'(1) << IDX_REV);
   localparam logic [NREG-1:0] EXT_MASK = MAP_MASK & ~INT_BITS;

   logic [NREG-1:0] sel;

   for (genvar i = 0; i < NREG; i++) begin : g_sel
      assign sel[i] = (index == DW'(i)) & MAP_MASK[i];
   end

   assign hit_int = sel[IDX_INT];
   assign hit_rev = sel[IDX_REV];
   assign hit_ext = |(sel & EXT_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en <= '0;
         rd_en <= '0;
      end else begin
         wr_en <= ev_wr ? (sel & EXT_MASK) : '0;
         rd_en <= ev_rd ? (sel & EXT_MASK) : '0;
      end
   end
endmodule

// File: rtl/mhb_irq.sv
module mhb_irq #(
   parameter int unsigned NSRC = 2,
   parameter int unsigned DW   = 8,
   parameter int unsigned STEP = 4,
   parameter int unsigned EOFS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_pulse,
   input  logic            rd_pulse,
   input  logic [NSRC-1:0] wen,
   input  logic [NSRC-1:0] src,
   output logic [DW-1:0]   image,
   output logic            irq_n
);
   logic [NSRC-1:0] en, pend, pend_nx;

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      assign pend_nx[k] = (src[k] & en[k]) | (pend[k] & ~rd_pulse);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en[k]   <= 1'b0;
            pend[k] <= 1'b0;
         end else begin
            if (wr_pulse) en[k] <= wen[k];
            pend[k] <= pend_nx[k];
         end
      end
   end

   always_comb begin
      image = '0;
      for (int k = 0; k < NSRC; k++) begin
         image[k*STEP]      = pend[k];
         image[k*STEP+EOFS] = en[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= ~|pend_nx;
   end
endmodule

// File: rtl/mhb_regif.sv
module mhb_regif
   import mhb_pkg::*;
#(
   parameter int unsigned NREG      = 16,
   parameter logic [NREG-1:0] MAP_MASK = NREG'(MHB_MAP_MASK),
   parameter int unsigned READY_CYC = 2,
   parameter bit          USE_ACK   = 1'b0,
   parameter logic [7:0]  REVISION  = 8'h21,
   parameter int unsigned NSRC      = MHB_NSRC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_cs_n,
   input  logic               bus_ad_sel,
   input  logic               bus_wr_n,
   input  logic               bus_rd_n,
   input  logic [7:0]         bus_din,
   output logic [7:0]         bus_dout,
   output logic               bus_doe,
   output logic               bus_rdy_n,
   output logic               bus_irq_n,
   output logic [NREG-1:0]    reg_wr_en,
   output logic [NREG-1:0]    reg_rd_en,
   output logic [7:0]         reg_wdata,
   input  logic [NREG*8-1:0]  reg_rdata_bank,
   input  logic               reg_ack,
   input  logic [NSRC-1:0]    irq_src
);
   localparam int unsigned DW    = MHB_DW;
   localparam int unsigned IDX_W = $clog2(NREG);

   if (READY_CYC < 1) begin : g_bad_ready
      $error("READY_CYC must be at least 1");
   end
   if (NREG < 16 || NREG > 256) begin : g_bad_nreg
      $error("NREG must lie in 16..256");
   end
   if (NSRC * MHB_SRC_STEP > DW) begin : g_bad_nsrc
      $error("NSRC does not fit in the interrupt control byte");
   end

   logic [3:0]    ctl_s;
   logic          cs_s, ad_s, wr_s, rd_s;
   logic [DW-1:0] dat_s;

   mhb_sync #(.W(4), .RST_VAL(4'b1011)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n),
      .d({bus_cs_n, bus_ad_sel, bus_wr_n, bus_rd_n}), .q(ctl_s));

   mhb_sync #(.W(DW), .RST_VAL('0)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d(bus_din), .q(dat_s));

   assign {cs_s, ad_s, wr_s, rd_s} = ctl_s;

   logic          ev_idx, ev_wr, ev_rd, busy;
   logic [DW-1:0] index;
   logic          need_ack;
   logic          hit_int, hit_rev, hit_ext;

   if (USE_ACK) begin : g_ack_wait
      assign need_ack = hit_ext;
   end else begin : g_ack_fixed
      assign need_ack = 1'b0;
   end

   mhb_phase #(.DW(DW), .READY_CYC(READY_CYC)) u_phase (
      .clk(clk), .rst_n(rst_n),
      .cs_s(cs_s), .ad_s(ad_s), .wr_s(wr_s), .rd_s(rd_s), .dat_s(dat_s),
      .need_ack(need_ack), .ack(reg_ack),
      .ev_idx(ev_idx), .ev_wr(ev_wr), .ev_rd(ev_rd),
      .index(index), .busy(busy));

   mhb_decode #(
      .NREG(NREG), .DW(DW), .MAP_MASK(MAP_MASK),
      .IDX_INT(MHB_IDX_INT), .IDX_REV(MHB_IDX_REV)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .index(index),
      .ev_wr(ev_wr), .ev_rd(ev_rd),
      .hit_int(hit_int), .hit_rev(hit_rev), .hit_ext(hit_ext),
      .wr_en(reg_wr_en), .rd_en(reg_rd_en));

   logic [NSRC-1:0] irq_wen;
   logic [DW-1:0]   irq_image;

   for (genvar k = 0; k < NSRC; k++) begin : g_wen
      assign irq_wen[k] = dat_s[k*MHB_SRC_STEP + MHB_EN_OFS];
   end

   mhb_irq #(
      .NSRC(NSRC), .DW(DW), .STEP(MHB_SRC_STEP), .EOFS(MHB_EN_OFS)
   ) u_irq (
      .clk(clk), .rst_n(rst_n),
      .wr_pulse(ev_wr & hit_int), .rd_pulse(ev_rd & hit_int),
      .wen(irq_wen), .src(irq_src),
      .image(irq_image), .irq_n(bus_irq_n));

   logic [DW-1:0] bank_byte;
   assign bank_byte = reg_rdata_bank[int'(index[IDX_W-1:0])*DW +: DW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_dout  <= '0;
         reg_wdata <= '0;
      end else begin
         if (ev_wr) reg_wdata <= dat_s;
         if (ev_rd) begin
            if (hit_int)      bus_dout <= irq_image;
            else if (hit_rev) bus_dout <= REVISION;
            else if (hit_ext) bus_dout <= bank_byte;
            else              bus_dout <= '0;
         end
      end
   end

   assign bus_doe   = ~bus_cs_n & ~bus_rd_n;
   assign bus_rdy_n = busy;
endmodule

// File: rtl/mhb_regif_chk.sv
module mhb_regif_chk #(
   parameter int unsigned NREG      = 16,
   parameter int unsigned READY_CYC = 2,
   parameter int unsigned NSRC      = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_rdy_n,
   input logic            bus_irq_n,
   input logic [NREG-1:0] reg_wr_en,
   input logic [NREG-1:0] reg_rd_en,
   input logic [NSRC-1:0] irq_src
);
   assert_wr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_wr_en));

   assert_rd_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_rd_en));

   assert_wr_rd_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !((|reg_wr_en) && (|reg_rd_en)));

   assert_enable_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((|reg_wr_en) || (|reg_rd_en)) |-> bus_rdy_n);

   if (READY_CYC >= 2) begin : g_width
      assert_ready_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(bus_rdy_n) |=> bus_rdy_n);
   end

   assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_irq_n) |-> $past(|irq_src));
endmodule

bind mhb_regif mhb_regif_chk #(.NREG(NREG), .READY_CYC(READY_CYC), .NSRC(NSRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rdy_n(bus_rdy_n), .bus_irq_n(bus_irq_n),
   .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .irq_src(irq_src));

// File: tb/tb_mhb_regif.sv
module tb_mhb_regif;
   localparam int NREG = 16;
   localparam int RCYC = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_cs_n = 1'b1, bus_ad_sel = 1'b0, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
   logic [7:0]        bus_din = '0;
   logic [7:0]        bus_dout;
   logic              bus_doe, bus_rdy_n, bus_irq_n;
   logic [NREG-1:0]   reg_wr_en, reg_rd_en;
   logic [7:0]        reg_wdata;
   logic [NREG*8-1:0] bank;
   logic              reg_ack = 1'b0;
   logic [1:0]        irq_src = '0;

   int n_chk = 0, n_bad = 0;
   int wr_cnt = 0, rd_cnt = 0, rdy_hi_seen = 0;
   logic [NREG-1:0] last_wr, last_rd;
   logic [7:0]      last_wd;

   always #2 clk = ~clk;

   mhb_regif dut (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_ad_sel(bus_ad_sel),
      .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_din(bus_din),
      .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rdy_n(bus_rdy_n),
      .bus_irq_n(bus_irq_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .reg_wdata(reg_wdata), .reg_rdata_bank(bank), .reg_ack(reg_ack),
      .irq_src(irq_src));

   function automatic logic [7:0] bankv(int i);
      return 8'((i * 29) ^ 8'h5A);
   endfunction

   always @(negedge clk) begin
      if (|reg_wr_en) begin wr_cnt++; last_wr = reg_wr_en; last_wd = reg_wdata; end
      if (|reg_rd_en) begin rd_cnt++; last_rd = reg_rd_en; end
      if (bus_rdy_n) rdy_hi_seen++;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input bit is_rd, input bit ad, input logic [7:0] d,
                         output logic [7:0] q, output int hi, output bit oe);
      int t;
      @(negedge clk);
      bus_din = d; bus_ad_sel = ad; bus_cs_n = 1'b0;
      @(negedge clk);
      if (is_rd) bus_rd_n = 1'b0; else bus_wr_n = 1'b0;
      t = 0;
      while (!bus_rdy_n && t < 20) begin @(negedge clk); t++; end
      hi = 0;
      while (bus_rdy_n && hi < 50) begin hi++; @(negedge clk); end
      q = bus_dout; oe = bus_doe;
      bus_rd_n = 1'b1; bus_wr_n = 1'b1;
      @(negedge clk);
      bus_cs_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic set_index(input logic [7:0] idx);
      logic [7:0] q; int hi; bit oe; int w0;
      w0 = wr_cnt;
      access(1'b0, 1'b1, idx, q, hi, oe);
      chk("R1 no enable on index write", 32'(wr_cnt - w0), 0);
   endtask

   task automatic do_write(input logic [7:0] d, output int hi);
      logic [7:0] q; bit oe;
      access(1'b0, 1'b0, d, q, hi, oe);
      chk("R3 doe low during write", 32'(oe), 0);
   endtask

   task automatic do_read(output logic [7:0] q, output int hi);
      bit oe;
      access(1'b1, 1'b0, 8'h00, q, hi, oe);
      chk("R3 doe high during read", 32'(oe), 1);
   endtask

   task automatic pulse_src(input int k);
      @(negedge clk); irq_src[k] = 1'b1;
      @(negedge clk); irq_src[k] = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   // kind(1) idx(8) data(8); kind 0 = write, 1 = read
   localparam logic [16:0] VEC [0:7] = '{
      {1'b0, 8'h01, 8'h3C}, {1'b1, 8'h04, 8'h00},
      {1'b0, 8'h06, 8'hA5}, {1'b1, 8'h07, 8'h00},
      {1'b0, 8'h0A, 8'hFF}, {1'b1, 8'h0C, 8'h00},
      {1'b0, 8'h0D, 8'h00}, {1'b1, 8'h09, 8'h00}};

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      logic [7:0] q; int hi; int w0, r0, h0;
      for (int i = 0; i < NREG; i++) bank[i*8 +: 8] = bankv(i);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R11 reset state
      chk("R11 rdy_n after reset", 32'(bus_rdy_n), 0);
      chk("R11 irq_n after reset", 32'(bus_irq_n), 1);
      chk("R11 doe after reset", 32'(bus_doe), 0);
      chk("R11 enables after reset", 32'({reg_wr_en, reg_rd_en}), 0);
      do_read(q, hi);
      chk("R11 index resets to interrupt control", 32'(q), 0);

      // table walk: R2, R3, R7
      for (int v = 0; v < 8; v++) begin
         w0 = wr_cnt; r0 = rd_cnt;
         set_index(VEC[v][15:8]);
         if (VEC[v][16]) begin
            do_read(q, hi);
            chk("R3 read byte", 32'(q), 32'(bankv(int'(VEC[v][15:8]))));
            chk("R3 read enable count", 32'(rd_cnt - r0), 1);
            chk("R3 read enable bit", 32'(last_rd), 32'(1) << VEC[v][15:8]);
         end else begin
            do_write(VEC[v][7:0], hi);
            chk("R2 write enable count", 32'(wr_cnt - w0), 1);
            chk("R2 write enable bit", 32'(last_wr), 32'(1) << VEC[v][15:8]);
            chk("R2 write byte", 32'(last_wd), 32'(VEC[v][7:0]));
         end
         chk("R7 ready width", 32'(hi), RCYC);
      end
      chk("R3 doe released", 32'(bus_doe), 0);

      // R12 index reuse
      set_index(8'h05);
      do_read(q, hi);
      chk("R12 first reuse read", 32'(q), 32'(bankv(5)));
      w0 = wr_cnt;
      do_write(8'h77, hi);
      chk("R12 reused write bit", 32'(last_wr), 32'(1) << 5);
      do_read(q, hi);
      chk("R12 second reuse read", 32'(q), 32'(bankv(5)));

      // R4 strobes with chip select high
      set_index(8'h04);
      w0 = wr_cnt; r0 = rd_cnt; h0 = rdy_hi_seen;
      @(negedge clk); bus_ad_sel = 1'b1; bus_din = 8'h06;
      bus_wr_n = 1'b0; repeat (6) @(negedge clk); bus_wr_n = 1'b1;
      bus_ad_sel = 1'b0; repeat (4) @(negedge clk);
      bus_rd_n = 1'b0; repeat (6) @(negedge clk); bus_rd_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R4 no enables without select", 32'((wr_cnt - w0) + (rd_cnt - r0)), 0);
      chk("R4 ready untouched", 32'(rdy_hi_seen - h0), 0);
      do_read(q, hi);
      chk("R4 index kept", 32'(q), 32'(bankv(4)));

      // R5 unmapped
      set_index(8'h02);
      do_read(q, hi);
      chk("R5 unmapped read 0x02", 32'(q), 0);
      w0 = wr_cnt;
      do_write(8'h11, hi);
      chk("R5 unmapped write ignored", 32'(wr_cnt - w0), 0);
      set_index(8'h40);
      do_read(q, hi);
      chk("R5 unmapped read 0x40", 32'(q), 0);

      // R6 revision
      set_index(8'h0F);
      do_read(q, hi);
      chk("R6 revision", 32'(q), 32'h21);
      w0 = wr_cnt;
      do_write(8'h99, hi);
      chk("R6 write pulses nothing", 32'(wr_cnt - w0), 0);
      do_read(q, hi);
      chk("R6 revision unchanged", 32'(q), 32'h21);

      // R10 disabled source
      pulse_src(0);
      pulse_src(1);
      chk("R10 irq stays high when disabled", 32'(bus_irq_n), 1);

      // R8 / R9 interrupt control
      set_index(8'h00);
      do_write(8'h44, hi);
      chk("R8 interrupt write pulses no external enable", 32'(last_wr), 32'(1) << 5);
      pulse_src(0);
      chk("R8 irq low after source 0", 32'(bus_irq_n), 0);
      do_read(q, hi);
      chk("R9 read shows source 0 pending", 32'(q), 32'h45);
      chk("R9 irq released by read", 32'(bus_irq_n), 1);
      pulse_src(1);
      chk("R8 irq low after source 1", 32'(bus_irq_n), 0);
      do_read(q, hi);
      chk("R9 read shows source 1 pending", 32'(q), 32'h54);
      do_read(q, hi);
      chk("R9 pending cleared", 32'(q), 32'h44);
      chk("R9 irq high after clear", 32'(bus_irq_n), 1);
      do_write(8'h04, hi);
      pulse_src(1);
      chk("R10 source 1 disabled again", 32'(bus_irq_n), 1);

      summary();
   end
endmodule